// File: doc/BRIEF.md
# Trigger-Aligned Debug Trace Buffer

This block captures a stream of trace records into a 64-entry circular store while a debug session is armed. A single trigger input decides where the capture window lies. Three alignment policies are available: capture up to the trigger, capture from the trigger on, or capture a fixed run of 32 records starting at the trigger. The fourth alignment code turns the whole facility off. Software reads every stored entry through a combinational read port, and reads the status through dedicated outputs.

The block is set up through one 8-bit configuration register. The register holds the arm bit, the trace mode, the alignment, a profiling enable and two timestamp enables. The fields can be changed only while the block is idle, although a write that clears the arm bit is always honoured. When profiling is enabled, arming starts a profiling session instead of a trace. No records are stored during that session and the trace mode has no effect. A free-running 16-bit counter supplies timestamps. A comparator-D match that arrives while an entry is being written tags that entry with the counter value, provided the mode and the enables allow it.

Top module: `trc_buffer_top`

## Requirements
- R1: After reset, `cfgRdData` reads 0x00 and `stCount`, `stArmed`, `stDone`, `stWrap` and `stProfiling` are all 0.
- R2: The configuration layout is: bit0 arm, bits[2:1] trace mode (00 normal, 01 loop1, 10 detail, 11 pure-PC), bits[4:3] alignment, bit5 profiling enable, bit6 timestamp function enable, bit7 comparator-D stamp enable. A write while idle loads bits[7:1]. A write while armed or profiling leaves bits[7:1] unchanged. Such a write disarms the block when its bit0 is 0 and does not set done. Bit0 reads back the armed state.
- R3: A trigger is ignored while the block is disarmed or profiling. After arming, only the first trigger changes the capture state.
- R4: With alignment 00, each valid record is stored from the cycle after arming onwards. The record in the trigger cycle is the last one stored, and capture then ends.
- R5: With alignment 01, no record is stored before the trigger. The record in the trigger cycle and every later record are stored until the block is disarmed.
- R6: With alignment 10, the block stores exactly 32 valid records, the first of which is the record in the trigger cycle, and then ends capture.
- R7: An arm write with alignment 11 is refused. The block stays disarmed, does not profile, and leaves the buffer and the status unchanged.
- R8: An arm write with profiling enabled (and alignment other than 11) sets `stProfiling` and `stArmed`. No record is stored until the block is disarmed, whatever the trace mode.
- R9: A stored entry carries the stamp flag and the 16-bit counter value of its write cycle only if comparator-D match is high in that cycle, bits 7 and 6 are both set, and the mode is not pure-PC. Otherwise the flag and the timestamp field are 0.
- R10: The buffer holds 64 entries, written at increasing addresses that wrap from 63 to 0. `stCount` saturates at 64. `stWrap` becomes 1 when an entry is overwritten.
- R11: An accepted arm write clears the write address, `stCount`, `stWrap` and `stDone`. When capture ends on its own, `stArmed` falls and `stDone` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write value |
| cfgRdData | output | 8 | Configuration readback, bit0 = armed |
| recValid | input | 1 | Trace record valid |
| recData | input | DATA_W | Trace record payload |
| trigPulse | input | 1 | Trigger pulse |
| dMatch | input | 1 | Comparator-D match pulse |
| rdAddr | input | log2(DEPTH) | Buffer read address |
| rdData | output | DATA_W | Payload at rdAddr |
| rdStamped | output | 1 | Stamp flag at rdAddr |
| rdTs | output | TS_W | Timestamp at rdAddr |
| stArmed | output | 1 | Tracing or profiling armed |
| stDone | output | 1 | Capture ended on its own |
| stProfiling | output | 1 | Profiling session active |
| stWrap | output | 1 | Buffer has been overwritten |
| stCount | output | log2(DEPTH+1) | Stored entries, saturating |

## Verification
A wrong capture state shows at the ports on the next clock edge. A misplaced window stores an entry where none should be, or misses one. `stCount` then differs right after the record is offered, and the readback shows a shifted payload sequence. A pointer or count fault shows as a wrong payload at some address, or as `stWrap` rising at the wrong entry. A fault in the gating of the enables shows as a wrong stamp flag or timestamp on the very entry that was written in the match cycle. A broken write lock shows as a changed configuration readback in the cycle after the write.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT,
    ST_REC,
    ST_POST,
    ST_PROF
  } capState_t;

  typedef struct packed {
    logic dstampEn;
    logic stampEn;
    logic profEn;
    logic [1:0] align;
    logic [1:0] mode;
  } trcCfg_t;

  typedef struct packed {
    logic clrBuf;
    logic wrEntry;
    logic stampEntry;
  } dpStrobe_t;

  localparam logic [1:0] MODE_PUREPC = 2'b11;
  localparam logic [1:0] ALIGN_END   = 2'b00;
  localparam logic [1:0] ALIGN_START = 2'b01;
  localparam logic [1:0] ALIGN_POST  = 2'b10;
  localparam logic [1:0] ALIGN_OFF   = 2'b11;

endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int POST_N = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  input  logic       trigPulse,
  input  logic       recValid,
  input  logic       dMatch,
  output logic [7:0] cfgRdData,
  output logic       stArmed,
  output logic       stDone,
  output logic       stProfiling,
  output dpStrobe_t  strobe
);

  localparam int PCW = $clog2(POST_N + 1);

  trcCfg_t   cfg_q;
  capState_t state_q, stNext;
  logic      done_q, doneSet;
  logic [PCW-1:0] postCnt_q, postNext;

  trcCfg_t newCfg;
  logic    isIdle, armReq, armOk, disarmReq, recording;

  assign newCfg    = trcCfg_t'(cfgWrData[7:1]);
  assign isIdle    = (state_q == ST_IDLE);
  assign armReq    = cfgWrEn && cfgWrData[0] && isIdle;
  assign armOk     = armReq && (newCfg.align != ALIGN_OFF);
  assign disarmReq = cfgWrEn && !cfgWrData[0] && !isIdle;

  assign recording = (state_q == ST_PRE) || (state_q == ST_REC) ||
                     (state_q == ST_POST) ||
                     ((state_q == ST_WAIT) && trigPulse);

  always_comb begin
    strobe.clrBuf     = armOk;
    strobe.wrEntry    = recording && recValid && !disarmReq;
    strobe.stampEntry = strobe.wrEntry && dMatch && cfg_q.dstampEn &&
                        cfg_q.stampEn && (cfg_q.mode != MODE_PUREPC);
  end

  always_comb begin
    stNext   = state_q;
    doneSet  = 1'b0;
    postNext = postCnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (armOk) begin
          postNext = '0;
          if (newCfg.profEn)                 stNext = ST_PROF;
          else if (newCfg.align == ALIGN_END) stNext = ST_PRE;
          else                               stNext = ST_WAIT;
        end
      end
      ST_PRE: begin
        if (trigPulse) begin
          stNext  = ST_IDLE;
          doneSet = 1'b1;
        end
      end
      ST_WAIT: begin
        if (trigPulse) begin
          if (cfg_q.align == ALIGN_START) begin
            stNext = ST_REC;
          end else begin
            stNext   = ST_POST;
            postNext = recValid ? PCW'(1) : '0;
          end
        end
      end
      ST_POST: begin
        if (recValid) begin
          postNext = postCnt_q + PCW'(1);
          if (postCnt_q == PCW'(POST_N - 1)) begin
            stNext  = ST_IDLE;
            doneSet = 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (disarmReq) begin
      stNext  = ST_IDLE;
      doneSet = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg_q     <= '0;
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      postCnt_q <= '0;
    end else begin
      if (cfgWrEn && isIdle) cfg_q <= newCfg;
      state_q   <= stNext;
      postCnt_q <= postNext;
      if (armOk)        done_q <= 1'b0;
      else if (doneSet) done_q <= 1'b1;
    end
  end

  assign cfgRdData   = {cfg_q, !isIdle};
  assign stArmed     = !isIdle;
  assign stDone      = done_q;
  assign stProfiling = (state_q == ST_PROF);

endmodule

// File: rtl/trc_datapath.sv
module trc_datapath
  import trc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  parameter int TS_W   = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] recData,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdStamped,
  output logic [TS_W-1:0]   rdTs,
  output logic              stWrap,
  output logic [CW-1:0]     stCount
);

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [TS_W-1:0]   tsMem   [DEPTH];
  logic [DEPTH-1:0]  stampMem;

  logic [AW-1:0]   wrPtr_q;
  logic [CW-1:0]   count_q;
  logic            wrap_q;
  logic [TS_W-1:0] tsCnt_q;
  logic            full;

  assign full = (count_q == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsCnt_q <= '0;
      wrPtr_q <= '0;
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      tsCnt_q <= tsCnt_q + TS_W'(1);
      if (strobe.clrBuf) begin
        wrPtr_q <= '0;
        count_q <= '0;
        wrap_q  <= 1'b0;
      end else if (strobe.wrEntry) begin
        wrPtr_q <= (wrPtr_q == AW'(DEPTH - 1)) ? '0 : wrPtr_q + AW'(1);
        if (full) wrap_q  <= 1'b1;
        else      count_q <= count_q + CW'(1);
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stampMem[gi] <= 1'b0;
        end else if (strobe.wrEntry && (wrPtr_q == AW'(gi))) begin
          stampMem[gi] <= strobe.stampEntry;
        end
      end
      always_ff @(posedge clk) begin
        if (strobe.wrEntry && (wrPtr_q == AW'(gi))) begin
          dataMem[gi] <= recData;
          tsMem[gi]   <= strobe.stampEntry ? tsCnt_q : '0;
        end
      end
    end
  endgenerate

  assign rdData    = dataMem[rdAddr];
  assign rdTs      = tsMem[rdAddr];
  assign rdStamped = stampMem[rdAddr];
  assign stWrap    = wrap_q;
  assign stCount   = count_q;

endmodule

// File: rtl/trc_buffer_top.sv
module trc_buffer_top
  import trc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  parameter int TS_W   = 16,
  parameter int POST_N = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              recValid,
  input  logic [DATA_W-1:0] recData,
  input  logic              trigPulse,
  input  logic              dMatch,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdStamped,
  output logic [TS_W-1:0]   rdTs,
  output logic              stArmed,
  output logic              stDone,
  output logic              stProfiling,
  output logic              stWrap,
  output logic [CW-1:0]     stCount
);

  dpStrobe_t strobe;

  trc_ctrl #(.POST_N(POST_N)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgWrData   (cfgWrData),
    .trigPulse   (trigPulse),
    .recValid    (recValid),
    .dMatch      (dMatch),
    .cfgRdData   (cfgRdData),
    .stArmed     (stArmed),
    .stDone      (stDone),
    .stProfiling (stProfiling),
    .strobe      (strobe)
  );

  trc_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TS_W(TS_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .recData   (recData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .rdStamped (rdStamped),
    .rdTs      (rdTs),
    .stWrap    (stWrap),
    .stCount   (stCount)
  );

endmodule

// File: rtl/trc_buffer_chk.sv
module trc_buffer_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          cfgWrEn,
  input logic [7:0]    cfgWrData,
  input logic [7:0]    cfgRdData,
  input logic          stArmed,
  input logic          stDone,
  input logic          stProfiling,
  input logic          stWrap,
  input logic [CW-1:0] stCount
);

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    stArmed |=> (cfgRdData[7:1] == $past(cfgRdData[7:1]))) else $error("cfg changed while armed"); // R2

  AST_RSVD_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !stArmed && cfgWrData[0] && (cfgWrData[4:3] == 2'b11)) |=> !stArmed) else $error("reserved align armed"); // R7

  AST_PROF_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    stProfiling |=> $stable(stCount)) else $error("entry stored while profiling"); // R8

  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (!stArmed && !cfgWrEn) |=> $stable(stCount)) else $error("entry stored while idle"); // R3

  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rstN)
    stCount <= CW'(DEPTH)) else $error("count overflow"); // R10

  AST_WRAP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    stWrap |-> (stCount == CW'(DEPTH))) else $error("wrap without full"); // R10

  AST_DONE_DISARMED: assert property (@(posedge clk) disable iff (!rstN)
    stDone |-> !stArmed) else $error("done while armed"); // R11

endmodule

bind trc_buffer_top trc_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWrEn     (cfgWrEn),
  .cfgWrData   (cfgWrData),
  .cfgRdData   (cfgRdData),
  .stArmed     (stArmed),
  .stDone      (stDone),
  .stProfiling (stProfiling),
  .stWrap      (stWrap),
  .stCount     (stCount)
);

// File: tb/trc_buffer_top_tb.sv
module trc_buffer_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        recValid = 1'b0;
  logic [15:0] recData = '0;
  logic        trigPulse = 1'b0;
  logic        dMatch = 1'b0;
  logic [5:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        rdStamped;
  logic [15:0] rdTs;
  logic        stArmed, stDone, stProfiling, stWrap;
  logic [6:0]  stCount;

  always #2.5 clk = ~clk;

  trc_buffer_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .recValid(recValid), .recData(recData),
    .trigPulse(trigPulse), .dMatch(dMatch), .rdAddr(rdAddr),
    .rdData(rdData), .rdStamped(rdStamped), .rdTs(rdTs),
    .stArmed(stArmed), .stDone(stDone), .stProfiling(stProfiling),
    .stWrap(stWrap), .stCount(stCount)
  );

  // Cycle counter kept by the bench: the timestamp counter runs freely from reset.
  logic [15:0] benchTs;
  always @(posedge clk) begin
    if (!rstN) benchTs <= '0;
    else       benchTs <= benchTs + 16'd1;
  end

  typedef struct packed {
    logic [15:0] d;
    logic        s;
    logic [15:0] ts;
  } item_t;

  item_t expQ[$];
  item_t expMem[64];
  int    expWp = 0;
  int    expCnt = 0;
  int    checks = 0;
  int    failures = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    expQ.delete();
    expWp = 0;
    expCnt = 0;
  endtask

  task automatic wrCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    recValid = 1'b0; trigPulse = 1'b0; dMatch = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Driver: offers one record and pushes the expected entry when one should be stored.
  task automatic drive(input logic [15:0] d, input bit trg, input bit dm,
                       input bit expWr, input bit expStamp);
    item_t it;
    @(negedge clk);
    recValid = 1'b1; recData = d; trigPulse = trg; dMatch = dm;
    if (expWr) begin
      it.d = d; it.s = expStamp; it.ts = expStamp ? benchTs : 16'd0;
      expQ.push_back(it);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    recValid = 1'b0; trigPulse = 1'b0; dMatch = 1'b0;
  endtask

  // Monitor: pops expected items into the address model and compares the readout.
  task automatic compareBuf(input string tag);
    item_t it;
    while (expQ.size() > 0) begin
      it = expQ.pop_front();
      expMem[expWp] = it;
      expWp = (expWp + 1) % 64;
      if (expCnt < 64) expCnt++;
    end
    check(stCount == 7'(expCnt), {tag, " count"}, int'(stCount), expCnt);
    for (int i = 0; i < expCnt; i++) begin
      rdAddr = 6'(i);
      #0.5;
      check(rdData == expMem[i].d, {tag, " data"}, int'(rdData), int'(expMem[i].d));
      check(rdStamped == expMem[i].s, {tag, " stamp"}, int'(rdStamped), int'(expMem[i].s));
      check(rdTs == expMem[i].ts, {tag, " ts"}, int'(rdTs), int'(expMem[i].ts));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cfgRdData == 8'h00, "R1 cfg", int'(cfgRdData), 0);
    check({stArmed, stDone, stWrap, stProfiling} == 4'b0, "R1 status", int'({stArmed, stDone, stWrap, stProfiling}), 0);
    check(stCount == 0, "R1 count", int'(stCount), 0);

    // R3 trigger while disarmed is ignored
    drive(16'hAAAA, 1, 0, 0, 0);
    idle();
    check(stCount == 0 && !stArmed && !stDone, "R3 disarmed trigger", int'(stCount), 0);

    // R4 end-at-trigger
    wrCfg(8'h01);
    modelClear();
    check(stArmed && cfgRdData == 8'h01, "R2 arm readback", int'(cfgRdData), 8'h01);
    for (int k = 0; k < 5; k++) drive(16'h0100 + 16'(k), k == 4, 0, 1, 0);
    idle();
    check(stDone && !stArmed, "R11 done after end-trigger", int'({stDone, stArmed}), 2);
    drive(16'h0200, 0, 0, 0, 0);
    drive(16'h0201, 1, 0, 0, 0);
    idle();
    compareBuf("R4");

    // R2 write protection while armed
    wrCfg(8'h09);
    check(!stDone, "R11 arm clears done", int'(stDone), 0);
    wrCfg(8'hF7);
    check(cfgRdData == 8'h09, "R2 locked write", int'(cfgRdData), 8'h09);
    wrCfg(8'hF6);
    check(cfgRdData == 8'h08 && !stArmed && !stDone, "R2 disarm write", int'(cfgRdData), 8'h08);

    // R5 start-at-trigger, R3 second trigger ignored
    wrCfg(8'h09);
    modelClear();
    for (int k = 0; k < 3; k++) drive(16'h0300 + 16'(k), 0, 0, 0, 0);
    idle();
    check(stCount == 0, "R5 nothing before trigger", int'(stCount), 0);
    drive(16'h0310, 1, 0, 1, 0);
    drive(16'h0311, 0, 0, 1, 0);
    drive(16'h0312, 0, 0, 1, 0);
    drive(16'h0313, 1, 0, 1, 0);
    idle();
    check(stArmed && !stDone, "R3 second trigger ignored", int'({stArmed, stDone}), 2);
    compareBuf("R5");
    wrCfg(8'h08);

    // R6 fixed post-trigger window
    wrCfg(8'h11);
    modelClear();
    drive(16'h0400, 0, 0, 0, 0);
    drive(16'h0401, 0, 0, 0, 0);
    for (int k = 0; k < 40; k++) drive(16'h0500 + 16'(k), (k == 0) || (k == 5), 0, k < 32, 0);
    idle();
    check(stDone && !stArmed, "R6 window end", int'({stDone, stArmed}), 2);
    compareBuf("R6");

    // R10 wrap and saturation, R11 arm clears state
    wrCfg(8'h09);
    modelClear();
    check(!stDone && stCount == 0, "R11 arm clears", int'(stCount), 0);
    for (int k = 0; k < 70; k++) begin
      drive(16'h0600 + 16'(k), k == 0, 0, 1, 0);
      if (k == 64) check(stCount == 64 && !stWrap, "R10 full no wrap", int'(stWrap), 0);
    end
    idle();
    check(stWrap && stCount == 64, "R10 wrap flag", int'(stWrap), 1);
    compareBuf("R10");
    wrCfg(8'h08);

    // R9 timestamps
    wrCfg(8'hC9);
    modelClear();
    check(!stWrap && stCount == 0, "R11 arm clears wrap", int'(stWrap), 0);
    drive(16'h0700, 1, 1, 1, 1);
    drive(16'h0701, 0, 0, 1, 0);
    drive(16'h0702, 0, 1, 1, 1);
    idle();
    compareBuf("R9 stamped");
    wrCfg(8'hC8);
    wrCfg(8'hCF);
    modelClear();
    drive(16'h0710, 1, 1, 1, 0);
    idle();
    compareBuf("R9 purepc");
    wrCfg(8'hCE);
    wrCfg(8'h89);
    modelClear();
    drive(16'h0720, 1, 1, 1, 0);
    idle();
    compareBuf("R9 stamp off");
    wrCfg(8'h88);

    // R8 profiling
    wrCfg(8'h27);
    modelClear();
    check(stProfiling && stArmed && stCount == 0, "R8 profiling on", int'(stProfiling), 1);
    drive(16'h0800, 1, 1, 0, 0);
    drive(16'h0801, 0, 0, 0, 0);
    idle();
    check(stCount == 0 && stProfiling && !stDone, "R8 no store", int'(stCount), 0);
    wrCfg(8'hFF);
    check(cfgRdData == 8'h27, "R2 locked while profiling", int'(cfgRdData), 8'h27);
    wrCfg(8'h26);
    check(!stProfiling && !stArmed, "R8 profiling off", int'(stProfiling), 0);

    // R7 reserved alignment
    wrCfg(8'h09);
    modelClear();
    drive(16'h0900, 1, 0, 1, 0);
    idle();
    wrCfg(8'h08);
    wrCfg(8'h19);
    check(!stArmed && cfgRdData == 8'h18, "R7 arm refused", int'(cfgRdData), 8'h18);
    drive(16'h0901, 1, 0, 0, 0);
    idle();
    compareBuf("R7");
    wrCfg(8'h39);
    check(!stArmed && !stProfiling, "R7 no profiling", int'({stArmed, stProfiling}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule